// File: doc/BRIEF.md
# Two-Phase Reading Storage Address Counter

This block keeps the slot address for a buffer of 50 stored readings. The buffer is filled in an input pass and then played back in an output pass. Each reading arrives as a count strobe. The strobe is widened to a fixed width and accepted only while the scanner gate is open. Each accepted strobe moves a decimal units digit forward, and every tenth step carries into a tens digit. The address runs from 1 up to 50. One step past 50 wraps it back to 1. That wrap ends a pass and flips the phase flag, so one input pass plus one output pass gives 100 states.

An input-hold request keeps the phase in input, so sampling into the buffer runs on without a break. In that mode each wrap also appears on the status flag, which marks every completed pass. A preset trigger lets a user end the hold once. The trigger is latched, and at the next wrap that ends an input pass the phase is forced to output and the latch clears. When that output pass ends, the phase goes back to input and the block waits for another trigger.

Top module: `rdg_store_seq`

## Requirements
- R1: A synchronous reset with `rst_n` low sets the following state at the next clock edge: units 1, tens 0, phase 0 (input), and `wrap_o`, `status_o` and `strobe_wide_o` all 0. It also clears the preset latch.
- R2: A rising edge on `count_in` seen while no stretch is running raises `strobe_wide_o` for exactly CLK_MHZ*PULSE_US clock cycles, starting at that edge. A rising edge that arrives while a stretch is running is ignored and does not step the address.
- R3: A strobe accepted while `scan_en` is 0 leaves the address unchanged.
- R4: Each counted strobe raises the units digit (`units_o`, BCD, 0 to 9) by one. A step from 9 sets units to 0 and raises the tens digit by one. The tens digit (`tens_o`) is binary, with bit 0 worth 10, bit 1 worth 20 and bit 2 worth 40.
- R5: From address 1, 49 counted strobes reach address 50 (tens 5, units 0). The 50th strobe returns the address to 1.
- R6: `wrap_o` is high for exactly one cycle, in the cycle in which the address first shows 1 after 50. It is never high at any other time.
- R7: When `in_hold` is 0, each wrap toggles `phase_o` (0 = input, 1 = output).
- R8: When `in_hold` is 1 at a wrap that ends an input pass and no preset is latched, `phase_o` stays 0.
- R9: A one-cycle pulse on `preset_trig` is latched. At the next wrap that ends an input pass, `phase_o` goes to 1 even while `in_hold` is 1, and the latch clears, so a later input-ending wrap under hold keeps the phase at 0.
- R10: A wrap that ends an output pass always sets `phase_o` to 0, whatever the level of `in_hold`.
- R11: `status_o` is high in the same single cycle as `wrap_o` when `in_hold` was 1 at the wrapping edge, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_in | input | 1 | Raw count strobe, one per reading |
| scan_en | input | 1 | Scanner gate, lets accepted strobes count |
| in_hold | input | 1 | Input-hold request |
| preset_trig | input | 1 | Preset trigger event, one cycle |
| units_o | output | 4 | Units address digit, BCD |
| tens_o | output | 3 | Tens address digit, weights 10/20/40 |
| phase_o | output | 1 | Phase flag, 0 input, 1 output |
| wrap_o | output | 1 | One-cycle end-of-pass pulse |
| status_o | output | 1 | Wrap pulse, passed only under input hold |
| strobe_wide_o | output | 1 | Stretched count strobe |

## Verification
The assertions check several rules on every cycle. The address stays within 1 to 50 with a units digit below ten. A wrap is seen only with the address at 1. The phase moves only on a wrap, a pass under hold with no latched preset stays in input, and an output pass always goes back to input. The status flag never appears without a wrap. Other behaviour needs the bench's scenarios to show: the exact stretch width, ignored retriggers, a latched preset taking effect at the next input-ending wrap and only that one, and whole passes of fifty steps under mixed hold patterns.

// File: rtl/rdg_pkg.sv
// Shared types for the reading storage address counter.
package rdg_pkg;
    typedef enum logic {
        PH_IN  = 1'b0,
        PH_OUT = 1'b1
    } phase_t;
endpackage

// File: rtl/strobe_stretch.sv
// Widens each rising edge of a count strobe to WIDTH_CYC cycles and
// emits a one-cycle accept at the start. Assumes the strobe is already
// synchronous to clk; edges during a running stretch are dropped.
module strobe_stretch #(
    parameter int WIDTH_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic accept_o,
    output logic wide_o
);
    localparam int CW = $clog2(WIDTH_CYC + 1);

    logic          prev_q;
    logic [CW-1:0] left_q;

    assign accept_o = strobe_i & ~prev_q & (left_q == '0);
    assign wide_o   = (left_q != '0);

    // Track the previous strobe level and count down the stretch window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            left_q <= '0;
        end else begin
            prev_q <= strobe_i;
            if (accept_o)
                left_q <= CW'(WIDTH_CYC);
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    // R2
    stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wide_o) |-> $past(strobe_i));
endmodule

// File: rtl/bcd_addr.sv
// Two-digit address counter running 1..TOP_TENS*DIGIT_MOD. Steps on
// step_i; at the top value the next step wraps to 1 and raises wrap_o
// for one cycle. wrap_now_o is the combinational wrap event.
module bcd_addr #(
    parameter int DIGIT_MOD = 10,
    parameter int TOP_TENS  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_i,
    output logic [$clog2(DIGIT_MOD)-1:0]  units_o,
    output logic [$clog2(TOP_TENS+1)-1:0] tens_o,
    output logic                          wrap_now_o,
    output logic                          wrap_o
);
    localparam int UW = $clog2(DIGIT_MOD);
    localparam int TW = $clog2(TOP_TENS + 1);

    logic [UW-1:0] units_q;
    logic [TW-1:0] tens_q;
    logic          wrap_q;
    logic          at_top;

    assign at_top     = (tens_q == TW'(TOP_TENS)) && (units_q == '0);
    assign wrap_now_o = step_i & at_top;
    assign units_o    = units_q;
    assign tens_o     = tens_q;
    assign wrap_o     = wrap_q;

    // Advance the digits with decade carry and wrap from the top to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units_q <= UW'(1);
            tens_q  <= '0;
            wrap_q  <= 1'b0;
        end else begin
            wrap_q <= wrap_now_o;
            if (step_i) begin
                if (at_top) begin
                    units_q <= UW'(1);
                    tens_q  <= '0;
                end else if (units_q == UW'(DIGIT_MOD - 1)) begin
                    units_q <= '0;
                    tens_q  <= tens_q + 1'b1;
                end else begin
                    units_q <= units_q + 1'b1;
                end
            end
        end
    end

    // R4
    units_decade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        units_q < UW'(DIGIT_MOD));
    // R5
    addr_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tens_q == '0 && units_q == '0) &&
        (tens_q < TW'(TOP_TENS) || units_q == '0));
    // R6
    wrap_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (units_q == UW'(1) && tens_q == '0 && $past(at_top)));
endmodule

// File: rtl/phase_ctl.sv
// Phase flag, preset override latch and status flag. Assumes wrap_i is
// the one-cycle wrap event from the address counter.
module phase_ctl
    import rdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic hold_i,
    input  logic preset_i,
    output logic phase_o,
    output logic status_o
);
    phase_t phase_q;
    logic   ovr_q;
    logic   stat_q;
    logic   end_input;

    assign end_input = wrap_i && (phase_q == PH_IN);
    assign phase_o   = phase_q;
    assign status_o  = stat_q;

    // Hold the preset override until an input pass ends.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= preset_i | (ovr_q & ~end_input);
    end

    // Pick the next phase at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IN;
        else if (wrap_i) begin
            if (phase_q == PH_OUT)     phase_q <= PH_IN;
            else if (ovr_q || !hold_i) phase_q <= PH_OUT;
            else                       phase_q <= PH_IN;
        end
    end

    // Pass the wrap event onto the status flag only under hold.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= wrap_i & hold_i;
    end

    // R7
    phase_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(phase_q));
    // R8
    hold_keeps_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_input && hold_i && !ovr_q) |=> (phase_q == PH_IN));
    // R9
    ovr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_input && ovr_q && !preset_i) |=> (!ovr_q && phase_q == PH_OUT));
    // R10
    out_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && phase_q == PH_OUT) |=> (phase_q == PH_IN));
    // R11
    status_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q |-> ($past(hold_i) && $past(wrap_i)));
endmodule

// File: rtl/rdg_store_seq.sv
// Top of the two-phase reading storage address counter. Stretches the
// count strobe, gates it with the scanner enable, steps the address and
// steers the input/output phase. Assumes synchronous inputs.
module rdg_store_seq #(
    parameter int CLK_MHZ   = 50,
    parameter int PULSE_US  = 4,
    parameter int DIGIT_MOD = 10,
    parameter int PASS_TENS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           count_in,
    input  logic                           scan_en,
    input  logic                           in_hold,
    input  logic                           preset_trig,
    output logic [$clog2(DIGIT_MOD)-1:0]   units_o,
    output logic [$clog2(PASS_TENS+1)-1:0] tens_o,
    output logic                           phase_o,
    output logic                           wrap_o,
    output logic                           status_o,
    output logic                           strobe_wide_o
);
    localparam int STRETCH_CYC = CLK_MHZ * PULSE_US;

    logic accept;
    logic step;
    logic wrap_now;

    strobe_stretch #(.WIDTH_CYC(STRETCH_CYC)) stretch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (count_in),
        .accept_o (accept),
        .wide_o   (strobe_wide_o)
    );

    assign step = accept & scan_en;

    bcd_addr #(.DIGIT_MOD(DIGIT_MOD), .TOP_TENS(PASS_TENS)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .units_o    (units_o),
        .tens_o     (tens_o),
        .wrap_now_o (wrap_now),
        .wrap_o     (wrap_o)
    );

    phase_ctl phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap_now),
        .hold_i   (in_hold),
        .preset_i (preset_trig),
        .phase_o  (phase_o),
        .status_o (status_o)
    );

    // R11
    status_with_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |-> wrap_o);
endmodule

// File: tb/rdg_store_seq_tb_top.sv
module rdg_store_seq_tb_top;
    localparam int S = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic count_in = 1'b0, scan_en = 1'b1, in_hold = 1'b0, preset_trig = 1'b0;
    logic [3:0] units_o;
    logic [2:0] tens_o;
    logic phase_o, wrap_o, status_o, strobe_wide_o;

    int n_chk = 0, n_bad = 0;
    int exp_addr = 1;
    bit done = 0;

    always #10 clk = ~clk;

    rdg_store_seq #(.CLK_MHZ(50), .PULSE_US(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .count_in(count_in), .scan_en(scan_en),
        .in_hold(in_hold), .preset_trig(preset_trig), .units_o(units_o),
        .tens_o(tens_o), .phase_o(phase_o), .wrap_o(wrap_o),
        .status_o(status_o), .strobe_wide_o(strobe_wide_o)
    );

    // {hold, preset, expected phase after pass, expected status at wrap}
    localparam logic [3:0] PASS_TAB [8] = '{
        4'b0010, 4'b0000, 4'b1001, 4'b1111,
        4'b1001, 4'b1001, 4'b0010, 4'b0000
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int addr_now();
        return int'(tens_o) * 10 + int'(units_o);
    endfunction

    // One strobe; returns wrap/status in the first cycle and wrap in the next.
    task automatic pulse_count(output bit w1, output bit s1, output bit w2);
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); count_in = 1'b0; w1 = wrap_o; s1 = status_o;
        @(negedge clk); w2 = wrap_o;
        repeat (S) @(negedge clk);
    endtask

    task automatic counted(output bit w1, output bit s1, output bit w2);
        pulse_count(w1, s1, w2);
        exp_addr = (exp_addr == 50) ? 1 : exp_addr + 1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_addr = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit w1, s1, w2;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(addr_now() == 1, "R1 addr", addr_now(), 1);
        chk(phase_o == 1'b0 && wrap_o == 0 && status_o == 0 && strobe_wide_o == 0,
            "R1 flags", {phase_o, wrap_o, status_o, strobe_wide_o}, 0);

        // Table of passes: R4 R5 R6 R7 R8 R9 R10 R11
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            in_hold = PASS_TAB[p][3];
            if (PASS_TAB[p][2]) begin
                preset_trig = 1'b1;
                @(negedge clk); preset_trig = 1'b0;
            end
            for (int k = 1; k <= 50; k++) begin
                counted(w1, s1, w2);
                chk(addr_now() == exp_addr, "R4/R5 address", addr_now(), exp_addr);
                if (k < 50) chk(w1 == 0, "R6 no early wrap", w1, 0);
                if (k == 49) chk(tens_o == 3'd5 && units_o == 4'd0, "R5 reach 50", addr_now(), 50);
            end
            chk(w1 == 1 && w2 == 0, "R6 single wrap", {w1, w2}, 2);
            chk(phase_o == PASS_TAB[p][1], "R7-R10 phase", phase_o, PASS_TAB[p][1]);
            chk(s1 == PASS_TAB[p][0], "R11 status", s1, PASS_TAB[p][0]);
        end
        in_hold = 1'b0;

        // R3 gate closed: no step
        scan_en = 1'b0;
        pulse_count(w1, s1, w2);
        chk(addr_now() == exp_addr, "R3 gated", addr_now(), exp_addr);
        scan_en = 1'b1;

        // R2 stretch width
        hi = 0;
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); count_in = 1'b0;
        for (int c = 0; c < S + 5; c++) begin
            if (strobe_wide_o) hi++;
            @(negedge clk);
        end
        exp_addr++;
        chk(hi == S, "R2 width", hi, S);
        chk(addr_now() == exp_addr, "R4 step", addr_now(), exp_addr);

        // R2 retrigger ignored
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); count_in = 1'b0;
        exp_addr++;
        repeat (5) @(negedge clk);
        count_in = 1'b1;
        @(negedge clk); count_in = 1'b0;
        repeat (S + 2) @(negedge clk);
        chk(addr_now() == exp_addr, "R2 retrigger", addr_now(), exp_addr);

        // R4 carry 9 -> 10
        while (exp_addr != 9) counted(w1, s1, w2);
        counted(w1, s1, w2);
        chk(tens_o == 3'd1 && units_o == 4'd0, "R4 carry", addr_now(), 10);

        // R1 reset mid-pass in output phase
        while (exp_addr != 50) counted(w1, s1, w2);
        counted(w1, s1, w2);
        chk(phase_o == 1'b1, "R7 to output", phase_o, 1);
        repeat (7) counted(w1, s1, w2);
        @(negedge clk); count_in = 1'b1;
        @(negedge clk); count_in = 1'b0;
        do_reset();
        chk(addr_now() == 1 && phase_o == 0 && strobe_wide_o == 0, "R1 mid reset",
            {addr_now(), phase_o, strobe_wide_o}, 1 << 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule